// File: doc/BRIEF.md
# External Interrupt Source Selector

This block sits between the general-purpose I/O ports of a chip and the external interrupt controller. Nine ports of sixteen pins each present their levels on a 144-bit input. The block drives sixteen interrupt lines. Line p carries pin p of the one port chosen for it. The choice for each line is a 4-bit field held in a small register file that software reaches over a simple 32-bit read/write bus.

Besides the four selection registers, the register file holds a 32-bit compensation-control register. It also decodes two configuration offsets whose writes are accepted but never stored. Offsets that decode to no register read as zero, drop writes, and raise a one-cycle error flag. Read data and the error flag come out one cycle after the access. The interrupt lines are combinational from the pins and the stored fields.

Top module: `exti_source_select`

## Requirements
- R1: After reset every register reads zero, and every line p follows pin p of port 0.
- R2: Line p follows the level of input bit k*16+p (port k, pin p) while its field holds k (0 to 8). Pins of every other port have no effect on it.
- R3: The field for line p sits in the selection register at byte offset 0x08 + 4*(p/4), in bits [(p%4)*4+3 : (p%4)*4].
- R4: A write to a selection register keeps only data bits [15:0]. Bits [31:16] of that register always read as zero.
- R5: A field value from 9 to 15 selects no port, and its line is held low.
- R6: Writes to the remap configuration offset 0x00 and the mode configuration offset 0x04 change no state. Reads of both return zero.
- R7: The compensation-control register at offset 0x20 stores and returns all 32 bits.
- R8: An access to any other offset in the 0x400-byte window reads zero and changes no register. Such offsets include unaligned offsets, 0x18, 0x1C and offsets 0x24 and above. The error output is high for exactly the one cycle after such an access, and is low after decoded accesses.
- R9: Read data appears on bus_rdata in the cycle after the read access and is zero otherwise. A new selection drives the lines from the clock edge that takes the write, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle flag for an undecoded access |
| port_pins | input | 144 | Port levels, bit k*16+p = port k pin p |
| exti_line | output | 16 | Selected interrupt levels |

## Verification
The selection path is tried with three kinds of pattern. In the first, only the addressed pin is high. In the second, every pin except the addressed one is high. In the third, port 0 carries a mixed word while the other ports are all ones. The single-high pattern shows that the selected port reaches the line. The single-low pattern shows that no other port leaks onto it. The mixed word shows that each line takes its own pin index. Field values at the edge (8, 9 and 15) separate a valid top port from the no-port codes. Write data with a non-zero upper half separates correct masking from storage of the full word.

// File: rtl/exti_sel_pkg.sv
package exti_sel_pkg;
    localparam int PORT_CNT   = 9;
    localparam int PIN_CNT    = 16;
    localparam int FIELD_W    = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 10;
    localparam int FIELDS_PER = 4;
    localparam int SEL_BASE   = 'h08;
    localparam int COMP_OFF   = 'h20;
    localparam int REMAP_OFF  = 'h00;
    localparam int MODE_OFF   = 'h04;

    typedef enum logic [2:0] {
        RID_REMAP,
        RID_MODE,
        RID_SEL,
        RID_COMP,
        RID_NONE
    } reg_id_e;
endpackage

// File: rtl/exti_addr_dec.sv
module exti_addr_dec
    import exti_sel_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int SEL_REGS = PIN_CNT / FIELDS_PER,
    parameter int IDX_W    = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1
) (
    input  logic [AW-1:0]    addr,
    output reg_id_e          rid,
    output logic [IDX_W-1:0] sel_idx
);
    localparam logic [AW-1:0] SEL_LO = AW'(SEL_BASE);
    localparam logic [AW-1:0] SEL_HI = AW'(SEL_BASE + 4 * SEL_REGS);

    logic [AW-1:0] off;

    always_comb begin
        off     = addr - SEL_LO;
        rid     = RID_NONE;
        sel_idx = off[IDX_W+1:2];
        if (addr[1:0] == 2'b00) begin
            if (addr == AW'(REMAP_OFF))
                rid = RID_REMAP;
            else if (addr == AW'(MODE_OFF))
                rid = RID_MODE;
            else if (addr == AW'(COMP_OFF))
                rid = RID_COMP;
            else if (addr >= SEL_LO && addr < SEL_HI)
                rid = RID_SEL;
        end
    end
endmodule

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs
    import exti_sel_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W,
    parameter int SEL_REGS = PIN_CNT / FIELDS_PER,
    parameter int FW       = FIELD_W,
    localparam int STORE_W = FIELDS_PER * FW,
    localparam int IDX_W   = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_en,
    input  logic                        acc_we,
    input  logic [AW-1:0]               acc_addr,
    input  logic [DW-1:0]               acc_wdata,
    output logic [DW-1:0]               acc_rdata,
    output logic                        acc_err,
    output logic [SEL_REGS*STORE_W-1:0] sel_flat
);
    localparam logic [DW-1:0] CFG_FIXED = '0;

    reg_id_e           rid;
    logic [IDX_W-1:0]  sel_idx;
    logic [STORE_W-1:0] sel_q [SEL_REGS];
    logic [DW-1:0]     comp_q;
    logic [DW-1:0]     rd_val;

    exti_addr_dec #(.AW(AW), .SEL_REGS(SEL_REGS), .IDX_W(IDX_W)) u_dec (
        .addr    (acc_addr),
        .rid     (rid),
        .sel_idx (sel_idx)
    );

    always_comb begin
        unique case (rid)
            RID_REMAP: rd_val = CFG_FIXED;
            RID_MODE:  rd_val = CFG_FIXED;
            RID_SEL:   rd_val = {{(DW-STORE_W){1'b0}}, sel_q[sel_idx]};
            RID_COMP:  rd_val = comp_q;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
            comp_q    <= '0;
            for (int i = 0; i < SEL_REGS; i++) sel_q[i] <= '0;
        end else begin
            acc_rdata <= (acc_en && !acc_we) ? rd_val : '0;
            acc_err   <= acc_en && (rid == RID_NONE);
            if (acc_en && acc_we) begin
                if (rid == RID_SEL)  sel_q[sel_idx] <= acc_wdata[STORE_W-1:0];
                if (rid == RID_COMP) comp_q <= acc_wdata;
            end
        end
    end

    for (genvar g = 0; g < SEL_REGS; g++) begin : g_flat
        assign sel_flat[g*STORE_W +: STORE_W] = sel_q[g];
    end
endmodule

// File: rtl/exti_line_mux.sv
module exti_line_mux #(
    parameter int PORTS = 9,
    parameter int FW    = 4
) (
    input  logic [PORTS-1:0] cand,
    input  logic [FW-1:0]    sel,
    output logic             line
);
    always_comb begin
        line = 1'b0;
        for (int k = 0; k < PORTS; k++) begin
            if (sel == FW'(k)) line = cand[k];
        end
    end
endmodule

// File: rtl/exti_source_select.sv
module exti_source_select
    import exti_sel_pkg::*;
#(
    parameter int PORTS = PORT_CNT,
    parameter int PINS  = PIN_CNT,
    parameter int FW    = FIELD_W,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    localparam int SEL_REGS = PINS / FIELDS_PER,
    localparam int FLAT_W   = SEL_REGS * FIELDS_PER * FW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_err,
    input  logic [PORTS*PINS-1:0] port_pins,
    output logic [PINS-1:0]       exti_line
);
    logic [FLAT_W-1:0] sel_flat;

    exti_cfg_regs #(.AW(AW), .DW(DW), .SEL_REGS(SEL_REGS), .FW(FW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (bus_en),
        .acc_we    (bus_we),
        .acc_addr  (bus_addr),
        .acc_wdata (bus_wdata),
        .acc_rdata (bus_rdata),
        .acc_err   (bus_err),
        .sel_flat  (sel_flat)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_line
        logic [PORTS-1:0] cand;
        for (genvar k = 0; k < PORTS; k++) begin : g_port
            assign cand[k] = port_pins[k*PINS + p];
        end
        exti_line_mux #(.PORTS(PORTS), .FW(FW)) u_mux (
            .cand (cand),
            .sel  (sel_flat[p*FW +: FW]),
            .line (exti_line[p])
        );
    end
endmodule

// File: rtl/exti_source_select_chk.sv
module exti_source_select_chk #(
    parameter int PINS  = 16,
    parameter int FW    = 4,
    parameter int PORTS = 9,
    parameter int AW    = 10,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_rdata,
    input logic             bus_err,
    input logic [PINS-1:0]  exti_line,
    input logic [PINS*FW-1:0] sel_flat
);
    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_en)); // R8
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0)); // R8
    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_en && !bus_we && bus_addr[1:0] == 2'b00 &&
              bus_addr >= AW'(8) && bus_addr < AW'(24))
        |-> (bus_rdata[DW-1:16] == '0)); // R4
    AST_CFG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_en && !bus_we && (bus_addr == AW'(0) || bus_addr == AW'(4)))
        |-> (bus_rdata == '0)); // R6
    AST_NO_READ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_en || bus_we) |-> (bus_rdata == '0)); // R9

    for (genvar p = 0; p < PINS; p++) begin : g_idle
        AST_IDLE_FIELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[p*FW +: FW] >= FW'(PORTS)) |-> !exti_line[p]); // R5
    end
endmodule

bind exti_source_select exti_source_select_chk #(
    .PINS(PINS), .FW(FW), .PORTS(PORTS), .AW(AW), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .exti_line (exti_line),
    .sel_flat  (sel_flat)
);

// File: tb/tb_exti_source_select.sv
module tb_exti_source_select;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [9:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [143:0] port_pins = '0;
    logic [15:0]  exti_line;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    exti_source_select dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .port_pins(port_pins), .exti_line(exti_line)
    );

    // entry: [15:12] line, [11:8] field value, [7:4] driven port, [0] expected level
    localparam logic [15:0] VEC [10] = '{
        16'h0001, 16'h5331, 16'h5320, 16'hF881, 16'hA870,
        16'h7900, 16'h3F80, 16'hC111, 16'h9661, 16'h2400
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) $display("FAIL %s actual=%h expected=%h", req, act, exp);
        else n_pass++;
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        err = bus_err;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, output logic err);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata; err = bus_err;
        bus_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and port 0 routing
        chk("R1 rdata idle", bus_rdata, 32'h0);
        chk("R1 err idle", {31'h0, bus_err}, 32'h0);
        foreach (VEC[i]) begin end
        for (int a = 0; a <= 'h20; a += 4) begin
            if (a == 'h18 || a == 'h1C) continue;
            bus_rd(10'(a), d, e);
            chk($sformatf("R1 reset reg %0h", a), d, 32'h0);
        end
        port_pins = {{128{1'b1}}, 16'h5A5A};
        #1 chk("R1 port0 default", {16'h0, exti_line}, 32'h5A5A);

        // R2/R5: table walk, single-high then single-low patterns
        for (int i = 0; i < 10; i++) begin
            int p, s, k;
            logic ex, ex2;
            p = int'(VEC[i][15:12]); s = int'(VEC[i][11:8]); k = int'(VEC[i][7:4]);
            ex = VEC[i][0];
            ex2 = (s < 9) && (s != k);
            bus_wr(10'(8 + 4*(p/4)), 32'(s) << ((p%4)*4), e);
            port_pins = '0;
            port_pins[k*16+p] = 1'b1;
            #1 chk($sformatf("R2/R5 vec%0d high", i), {31'h0, exti_line[p]}, {31'h0, ex});
            port_pins = '1;
            port_pins[k*16+p] = 1'b0;
            #1 chk($sformatf("R2/R5 vec%0d low", i), {31'h0, exti_line[p]}, {31'h0, ex2});
        end

        // R3: field placement inside register 0x0C
        bus_wr(10'h08, 32'h0, e); bus_wr(10'h10, 32'h0, e); bus_wr(10'h14, 32'h0, e);
        bus_wr(10'h0C, 32'h0000_3210, e);
        port_pins = '0;
        port_pins[1*16+5] = 1'b1;
        port_pins[3*16+7] = 1'b1;
        #1 chk("R3 field position", {16'h0, exti_line}, 32'h00A0);

        // R4: upper half dropped
        bus_wr(10'h08, 32'hDEAD_BEEF, e);
        bus_rd(10'h08, d, e);
        chk("R4 masked readback", d, 32'h0000_BEEF);

        // R7: compensation register
        bus_wr(10'h20, 32'h1234_5678, e);
        bus_rd(10'h20, d, e);
        chk("R7 comp readback", d, 32'h1234_5678);
        chk("R8 no err on decoded", {31'h0, e}, 32'h0);

        // R6: ignored config writes
        bus_wr(10'h00, 32'hFFFF_FFFF, e);
        chk("R6 remap write no err", {31'h0, e}, 32'h0);
        bus_wr(10'h04, 32'hFFFF_FFFF, e);
        bus_rd(10'h00, d, e);
        chk("R6 remap reads zero", d, 32'h0);
        bus_rd(10'h04, d, e);
        chk("R6 mode reads zero", d, 32'h0);

        // R8: undecoded offsets
        bus_rd(10'h18, d, e);
        chk("R8 undecoded read data", d, 32'h0);
        chk("R8 err raised", {31'h0, e}, 32'h1);
        @(posedge clk); #1;
        chk("R8 err one cycle", {31'h0, bus_err}, 32'h0);
        bus_wr(10'h09, 32'hFFFF_FFFF, e);
        chk("R8 unaligned err", {31'h0, e}, 32'h1);
        bus_wr(10'h1C, 32'hFFFF_FFFF, e);
        bus_wr(10'h3FC, 32'hFFFF_FFFF, e);
        chk("R8 high offset err", {31'h0, e}, 32'h1);
        bus_rd(10'h08, d, e);
        chk("R8 sel unchanged", d, 32'h0000_BEEF);
        bus_rd(10'h20, d, e);
        chk("R8 comp unchanged", d, 32'h1234_5678);

        // R9: selection takes effect at the write edge
        bus_wr(10'h08, 32'h0, e);
        port_pins = '0;
        port_pins[2*16+0] = 1'b1;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 10'h08; bus_wdata = 32'h2;
        #1 chk("R9 before edge", {31'h0, exti_line[0]}, 32'h0);
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
        chk("R9 after edge", {31'h0, exti_line[0]}, 32'h1);
        chk("R9 rdata zero after write", bus_rdata, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule